// File: doc/BRIEF.md
# Bypassed Speculative Register Map Table

This block holds the mapping from architectural register numbers to physical register numbers for a rename stage that handles several instructions per cycle. It keeps two copies of the map. The speculative copy is updated by rename writes. The architectural copy is updated by retirement (commit) writes. Lookups start one stage early: an address is presented in one cycle, and the mapping appears in the next cycle. Writes are captured in a register and reach the table one cycle after they are presented. A forwarding path from the captured writes to the read result makes every lookup reflect all rename writes presented up to and including the cycle of its address.

A rename write lane can mark its instruction as an eliminated move. The lane then maps its destination to whatever physical register currently holds the move's source. That mapping includes writes from lower lanes of the same group. A flush replaces the whole speculative copy with the architectural copy in a single cycle. Architectural register 0 is hard-wired to physical register 0.

Top module: `rename_map_table`

## Requirements
- R1: While reset is asserted, both copies load the identity map: architectural register i maps to physical register i. Every read port outputs 0 in the first cycle after reset.
- R2: A read address presented on `rd_addr[p]` in cycle t produces its mapping on `rd_data[p]` throughout cycle t+1. All read ports work independently and at the same time.
- R3: The value read in cycle t+1 reflects every rename write presented in cycles up to and including t. It does not reflect rename writes presented in cycle t+1.
- R4: When several rename lanes in one cycle write the same architectural register, the lane with the highest index wins. This holds both for the forwarded value and for the stored value.
- R5: A rename lane with `sp_move` set ignores its `sp_pdst`. It maps `sp_dst` to the physical register that `sp_msrc` maps to after all earlier cycles' writes and the writes of lower-indexed lanes in the same cycle.
- R6: Reading architectural register 0 always returns 0. Rename and commit writes to register 0 have no effect, including an eliminated move whose destination is 0. A move whose source is register 0 maps its destination to physical register 0.
- R7: A flush in cycle t makes reads from cycle t+1 onward see the architectural copy as updated by commit writes presented before cycle t. Rename writes presented in cycle t-1 and in cycle t are discarded.
- R8: Commit writes change only the architectural copy, with the highest lane winning. They become visible at the read ports only after a later flush.
- R9: In a cycle with no rename write and no flush, the value read for an unchanged address stays the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Restore the speculative copy from the architectural copy |
| rd_addr | input | RD_PORTS x ARCH_W | Lookup addresses, one per read port |
| rd_data | output | RD_PORTS x PHYS_W | Physical register for each lookup, one cycle after its address |
| sp_wen | input | LANES | Rename write enable per lane |
| sp_move | input | LANES | Lane carries an eliminated move |
| sp_dst | input | LANES x ARCH_W | Rename destination architectural register |
| sp_msrc | input | LANES x ARCH_W | Source architectural register of an eliminated move |
| sp_pdst | input | LANES x PHYS_W | New physical register for a plain rename write |
| cm_wen | input | LANES | Commit write enable per lane |
| cm_dst | input | LANES x ARCH_W | Committed architectural register |
| cm_pdst | input | LANES x PHYS_W | Committed physical register |

## Verification
Each lookup result is due exactly one clock after its address. The bench therefore applies each cycle's stimulus at a falling edge, updates its reference model with that cycle's writes, and compares every read port at the next falling edge, after the capturing rising edge.

The model applies writes and the flush in the same order the block must: a flush first copies the architectural map as it stood before this cycle's commits, then rename lanes are applied in ascending order. This gives one cycle of forwarding latency for rename writes, and it makes commit writes visible only through a later flush.

Directed sequences cover the cases that need them:
- same-cycle write and read;
- same-register lane collisions;
- chained moves;
- register 0;
- a commit followed by a flush;
- idle hold cycles.

Seeded random traffic with a narrowed destination range forces frequent collisions.

// File: rtl/rmt_pkg.sv
package rmt_pkg;

    localparam int unsigned NUM_ARCH      = 32;
    localparam int unsigned ARCH_W        = $clog2(NUM_ARCH);
    localparam int unsigned NUM_PHYS      = 128;
    localparam int unsigned PHYS_W        = $clog2(NUM_PHYS);
    localparam int unsigned LANES         = 4;
    localparam int unsigned PORTS_PER_LANE = 3;
    localparam int unsigned RD_PORTS      = LANES * PORTS_PER_LANE;

    typedef logic [ARCH_W-1:0] areg_t;
    typedef logic [PHYS_W-1:0] preg_t;
    typedef preg_t [NUM_ARCH-1:0] map_t;

    // captured rename write of one lane
    typedef struct packed {
        logic  vld;
        logic  mv;
        areg_t dst;
        areg_t msrc;
        preg_t pdst;
    } spec_wr_t;

    // captured commit write of one lane
    typedef struct packed {
        logic  vld;
        areg_t dst;
        preg_t pdst;
    } cm_wr_t;

    function automatic map_t ident_map();
        map_t m;
        for (int i = 0; i < int'(NUM_ARCH); i++) begin
            m[i] = preg_t'(i);
        end
        return m;
    endfunction

endpackage

// File: rtl/rmt_move_resolve.sv
// Turns each captured rename lane into its final physical register.
// Eliminated moves take the source mapping, seen through lower lanes first.
module rmt_move_resolve
    import rmt_pkg::*;
(
    input  map_t                  table_i,
    input  spec_wr_t [LANES-1:0]  wr_i,
    output preg_t    [LANES-1:0]  pdst_o
);

    always_comb begin
        preg_t [LANES-1:0] res;
        preg_t             src_val;
        res = '0;
        for (int i = 0; i < int'(LANES); i++) begin
            if (wr_i[i].msrc == '0) begin
                src_val = '0;
            end else begin
                src_val = table_i[wr_i[i].msrc];
            end
            for (int j = 0; j < i; j++) begin
                if (wr_i[j].vld && (wr_i[j].dst == wr_i[i].msrc)) begin
                    src_val = res[j];
                end
            end
            res[i] = wr_i[i].mv ? src_val : wr_i[i].pdst;
        end
        pdst_o = res;
    end

endmodule

// File: rtl/rmt_read_port.sv
// One lookup: stored mapping overridden by captured writes, highest lane last.
module rmt_read_port
    import rmt_pkg::*;
(
    input  areg_t               addr_i,
    input  map_t                table_i,
    input  logic  [LANES-1:0]   vld_i,
    input  areg_t [LANES-1:0]   dst_i,
    input  preg_t [LANES-1:0]   pdst_i,
    output preg_t               data_o
);

    always_comb begin
        data_o = table_i[addr_i];
        for (int j = 0; j < int'(LANES); j++) begin
            if (vld_i[j] && (dst_i[j] == addr_i)) begin
                data_o = pdst_i[j];
            end
        end
        if (addr_i == '0) begin
            data_o = '0;
        end
    end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
    import rmt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [RD_PORTS-1:0][ARCH_W-1:0]   rd_addr,
    output logic [RD_PORTS-1:0][PHYS_W-1:0]   rd_data,
    input  logic [LANES-1:0]                  sp_wen,
    input  logic [LANES-1:0]                  sp_move,
    input  logic [LANES-1:0][ARCH_W-1:0]      sp_dst,
    input  logic [LANES-1:0][ARCH_W-1:0]      sp_msrc,
    input  logic [LANES-1:0][PHYS_W-1:0]      sp_pdst,
    input  logic [LANES-1:0]                  cm_wen,
    input  logic [LANES-1:0][ARCH_W-1:0]      cm_dst,
    input  logic [LANES-1:0][PHYS_W-1:0]      cm_pdst
);

    typedef struct packed {
        map_t                      spec;
        map_t                      arch;
        areg_t    [RD_PORTS-1:0]   raddr;
        spec_wr_t [LANES-1:0]      swr;
        cm_wr_t   [LANES-1:0]      cwr;
    } state_t;

    state_t st_d, st_q;

    // resolved view of the captured rename writes
    logic  [LANES-1:0]  wr_vld;
    areg_t [LANES-1:0]  wr_dst;
    preg_t [LANES-1:0]  wr_res;

    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            wr_vld[i] = st_q.swr[i].vld;
            wr_dst[i] = st_q.swr[i].dst;
        end
    end

    rmt_move_resolve u_resolve (
        .table_i (st_q.spec),
        .wr_i    (st_q.swr),
        .pdst_o  (wr_res)
    );

    for (genvar p = 0; p < int'(RD_PORTS); p++) begin : g_rd
        rmt_read_port u_port (
            .addr_i  (st_q.raddr[p]),
            .table_i (st_q.spec),
            .vld_i   (wr_vld),
            .dst_i   (wr_dst),
            .pdst_i  (wr_res),
            .data_o  (rd_data[p])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.raddr = rd_addr;

        // capture this cycle's requests; register 0 writes dropped here
        for (int i = 0; i < int'(LANES); i++) begin
            st_d.swr[i].vld  = sp_wen[i] && !flush && (sp_dst[i] != '0);
            st_d.swr[i].mv   = sp_move[i];
            st_d.swr[i].dst  = sp_dst[i];
            st_d.swr[i].msrc = sp_msrc[i];
            st_d.swr[i].pdst = sp_pdst[i];
            st_d.cwr[i].vld  = cm_wen[i] && (cm_dst[i] != '0);
            st_d.cwr[i].dst  = cm_dst[i];
            st_d.cwr[i].pdst = cm_pdst[i];
        end

        // apply last cycle's commit writes, lane order gives priority
        for (int i = 0; i < int'(LANES); i++) begin
            if (st_q.cwr[i].vld) begin
                st_d.arch[st_q.cwr[i].dst] = st_q.cwr[i].pdst;
            end
        end

        // speculative copy: restore on flush, else apply last cycle's renames
        if (flush) begin
            st_d.spec = st_d.arch;
        end else begin
            for (int i = 0; i < int'(LANES); i++) begin
                if (st_q.swr[i].vld) begin
                    st_d.spec[st_q.swr[i].dst] = wr_res[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.spec <= ident_map();
            st_q.arch <= ident_map();
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rmt_chk.sv
module rmt_chk
    import rmt_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [RD_PORTS-1:0][ARCH_W-1:0]   rd_addr,
    input  logic [RD_PORTS-1:0][PHYS_W-1:0]   rd_data,
    input  logic [LANES-1:0]                  sp_wen,
    input  logic [LANES-1:0]                  sp_move,
    input  logic [LANES-1:0][ARCH_W-1:0]      sp_dst,
    input  logic [LANES-1:0][PHYS_W-1:0]      sp_pdst
);

    localparam int unsigned TOP = LANES - 1;

    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    for (genvar p = 0; p < int'(RD_PORTS); p++) begin : g_port
        // R6
        zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q != 2'd0 && $past(rd_addr[p] == '0)) |-> (rd_data[p] == '0));

        // R3 R4
        lane_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q != 2'd0 && $past(sp_wen[TOP] && !sp_move[TOP] && !flush &&
                                    sp_dst[TOP] != '0 && sp_dst[TOP] == rd_addr[p]))
            |-> (rd_data[p] == $past(sp_pdst[TOP])));

        // R9
        data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && $past(rd_addr[p]) == $past(rd_addr[p], 2) &&
             !$past((|sp_wen) || flush)) |-> $stable(rd_data[p]));

        if (p > 0) begin : g_pair
            // R2
            port_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q != 2'd0 && $past(rd_addr[p] == rd_addr[0])) |-> (rd_data[p] == rd_data[0]));
        end
    end

endmodule

bind rename_map_table rmt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .sp_wen  (sp_wen),
    .sp_move (sp_move),
    .sp_dst  (sp_dst),
    .sp_pdst (sp_pdst)
);

// File: tb/rename_map_table_test.sv
`timescale 1ns/1ps
module rename_map_table_test;
    import rmt_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush;
    logic [RD_PORTS-1:0][ARCH_W-1:0] rd_addr;
    logic [RD_PORTS-1:0][PHYS_W-1:0] rd_data;
    logic [LANES-1:0]                sp_wen, sp_move, cm_wen;
    logic [LANES-1:0][ARCH_W-1:0]    sp_dst, sp_msrc, cm_dst;
    logic [LANES-1:0][PHYS_W-1:0]    sp_pdst, cm_pdst;

    always #5 clk = ~clk;

    rename_map_table uut (.*);

    int    vectors = 0;
    int    errs = 0;
    string tag = "R1";
    int    spec_m [NUM_ARCH];
    int    arch_m [NUM_ARCH];
    logic [RD_PORTS-1:0][PHYS_W-1:0] exp_d;

    task automatic idle_inputs();
        flush = 1'b0; rd_addr = '0;
        sp_wen = '0; sp_move = '0; sp_dst = '0; sp_msrc = '0; sp_pdst = '0;
        cm_wen = '0; cm_dst = '0; cm_pdst = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    endtask

    // reference: flush restores from arch (pre-commit of this cycle), renames in lane order
    task automatic step();
        if (flush) begin
            for (int a = 0; a < int'(NUM_ARCH); a++) spec_m[a] = arch_m[a];
        end else begin
            for (int i = 0; i < int'(LANES); i++) begin
                if (sp_wen[i] && sp_dst[i] != '0) begin
                    if (sp_move[i]) spec_m[sp_dst[i]] = (sp_msrc[i] == '0) ? 0 : spec_m[sp_msrc[i]];
                    else            spec_m[sp_dst[i]] = int'(sp_pdst[i]);
                end
            end
        end
        for (int i = 0; i < int'(LANES); i++) begin
            if (cm_wen[i] && cm_dst[i] != '0) arch_m[cm_dst[i]] = int'(cm_pdst[i]);
        end
        for (int p = 0; p < int'(RD_PORTS); p++) begin
            exp_d[p] = (rd_addr[p] == '0) ? '0 : preg_t'(spec_m[rd_addr[p]]);
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < int'(RD_PORTS); p++) begin
            vectors++;
            if (rd_data[p] !== exp_d[p]) begin
                errs++;
                $display("FAIL %s port %0d actual %0d expected %0d", tag, p, rd_data[p], exp_d[p]);
            end
        end
    endtask

    task automatic read_block(input int base);
        for (int p = 0; p < int'(RD_PORTS); p++) rd_addr[p] = areg_t'((base + p) % int'(NUM_ARCH));
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        for (int a = 0; a < int'(NUM_ARCH); a++) begin spec_m[a] = a; arch_m[a] = a; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: first cycle after reset, all ports 0
        for (int p = 0; p < int'(RD_PORTS); p++) begin
            vectors++;
            if (rd_data[p] !== '0) begin
                errs++;
                $display("FAIL R1 port %0d actual %0d expected 0", p, rd_data[p]);
            end
        end
        // R1: identity map over all registers
        tag = "R1";
        read_block(0);  step();
        read_block(12); step();
        read_block(24); step();

        // R3: same-cycle write forwarded, later write not yet visible
        tag = "R3";
        idle_inputs();
        rd_addr[0] = 5; sp_wen[0] = 1; sp_dst[0] = 5; sp_pdst[0] = 100; step();
        sp_pdst[0] = 101; step();
        sp_wen = '0; step();

        // R4: all lanes hit register 7, highest wins
        tag = "R4";
        idle_inputs();
        rd_addr[3] = 7;
        for (int i = 0; i < int'(LANES); i++) begin
            sp_wen[i] = 1; sp_dst[i] = 7; sp_pdst[i] = preg_t'(40 + i);
        end
        step();
        sp_wen = '0; step();

        // R5: move chain through lower lanes, then from the table
        tag = "R5";
        idle_inputs();
        sp_wen[0] = 1; sp_dst[0] = 3; sp_pdst[0] = 50;
        sp_wen[1] = 1; sp_move[1] = 1; sp_dst[1] = 9; sp_msrc[1] = 3; sp_pdst[1] = 99;
        sp_wen[2] = 1; sp_move[2] = 1; sp_dst[2] = 10; sp_msrc[2] = 9; sp_pdst[2] = 98;
        rd_addr[0] = 3; rd_addr[1] = 9; rd_addr[2] = 10;
        step();
        idle_inputs();
        sp_wen[3] = 1; sp_move[3] = 1; sp_dst[3] = 11; sp_msrc[3] = 10;
        rd_addr[4] = 11; step();
        sp_wen = '0; step();

        // R6: register 0 writes ignored, move from 0 gives 0
        tag = "R6";
        idle_inputs();
        sp_wen[0] = 1; sp_dst[0] = 0; sp_pdst[0] = 77;
        sp_wen[1] = 1; sp_move[1] = 1; sp_dst[1] = 0; sp_msrc[1] = 3;
        sp_wen[2] = 1; sp_move[2] = 1; sp_dst[2] = 4; sp_msrc[2] = 0;
        cm_wen[0] = 1; cm_dst[0] = 0; cm_pdst[0] = 66;
        rd_addr[0] = 0; rd_addr[1] = 4; step();
        idle_inputs(); rd_addr[0] = 0; rd_addr[1] = 4; flush = 1; step();
        flush = 0; step();

        // R8: commit invisible until flush
        tag = "R8";
        idle_inputs();
        cm_wen[2] = 1; cm_dst[2] = 6; cm_pdst[2] = 77;
        cm_wen[3] = 1; cm_dst[3] = 6; cm_pdst[3] = 78;
        sp_wen[1] = 1; sp_dst[1] = 6; sp_pdst[1] = 88;
        rd_addr[0] = 6; step();
        idle_inputs(); rd_addr[0] = 6; step();
        // R7: flush drops pending and same-cycle renames
        tag = "R7";
        sp_wen[0] = 1; sp_dst[0] = 12; sp_pdst[0] = 120; rd_addr[1] = 12; step();
        sp_dst[0] = 13; sp_pdst[0] = 121; rd_addr[2] = 13; flush = 1; step();
        idle_inputs(); rd_addr[0] = 6; rd_addr[1] = 12; rd_addr[2] = 13; step();

        // R9: idle hold
        tag = "R9";
        read_block(3);
        repeat (4) step();

        // R2: random traffic with collisions
        tag = "R2";
        for (int c = 0; c < 3000; c++) begin
            idle_inputs();
            flush = ($urandom % 32) == 0;
            for (int i = 0; i < int'(LANES); i++) begin
                sp_wen[i]  = $urandom % 2;
                sp_move[i] = ($urandom % 4) == 0;
                sp_dst[i]  = areg_t'((($urandom % 4) == 0) ? $urandom % 4 : $urandom % NUM_ARCH);
                sp_msrc[i] = areg_t'((($urandom % 4) == 0) ? $urandom % 4 : $urandom % NUM_ARCH);
                sp_pdst[i] = preg_t'($urandom % NUM_PHYS);
                cm_wen[i]  = $urandom % 2;
                cm_dst[i]  = areg_t'($urandom % NUM_ARCH);
                cm_pdst[i] = preg_t'($urandom % NUM_PHYS);
            end
            for (int p = 0; p < int'(RD_PORTS); p++) begin
                rd_addr[p] = areg_t'((($urandom % 3) == 0) ? $urandom % 4 : $urandom % NUM_ARCH);
            end
            step();
        end
        finish_run();
    end

endmodule